// File: doc/BRIEF.md
# Multi-mode GPIO pin controller

This block controls a bank of general-purpose pins through a small register bus. The low-numbered pins are shared with a peripheral; the rest are dedicated to GPIO. Software gives every pin one of four modes. It can float the pin as an input. It can hand the pin to its peripheral, whose output value and output enable then reach the pad. It can also force the pin low or force it high. The mode can be changed at any time while running.

The mode is stored as two bit planes, M1 and M0, so each pin's mode code is `{M1,M0}`. Each plane has three addresses: a plain read/write address, a write-one-to-set alias and a write-one-to-clear alias. One access can therefore move any group of pins without disturbing the others. A pin-state register returns the live pad levels after a two-flop synchronizer, whatever mode each pin is in.

Register map (3-bit word address, data width equals the pin count):

| Address | Name | Write effect | Read value |
|---|---|---|---|
| 0 | PIN | none | synchronized pad levels |
| 1 | M0 | load | M0 |
| 2 | M0_SET | M0 \|= data | M0 |
| 3 | M0_CLR | M0 &= ~data | M0 |
| 4 | M1 | load | M1 |
| 5 | M1_SET | M1 \|= data | M1 |
| 6 | M1_CLR | M1 &= ~data | M1 |
| 7 | none | none | 0 |

Top module: `pin_mode_ctrl`

## Requirements
- R1: After reset, M0 has a 1 in every shared pin position (bits 0 to NUM_SHARED-1) and a 0 in every other position, and M1 is all zeros. Shared pins therefore start in peripheral mode and dedicated pins start as inputs.
- R2: A pin with mode code 00 (input) drives pad_oe_o low and pad_out_o low.
- R3: A shared pin with mode code 01 (peripheral) drives pad_out_o from periph_out_i and pad_oe_o from periph_oe_i. This path is combinational, with no clock delay.
- R4: Mode code 10 drives pad_oe_o=1 and pad_out_o=0. Mode code 11 drives pad_oe_o=1 and pad_out_o=1.
- R5: A dedicated pin (index NUM_SHARED or higher) has no peripheral mode. With code 01 it behaves as an input, with pad_oe_o=0 and pad_out_o=0.
- R6: A write to a set alias (address 2 or 5) ORs the write data into that plane. Bits written as 0 keep their value.
- R7: A write to a clear alias (address 3 or 6) clears the plane bits written as 1. Bits written as 0 keep their value.
- R8: A write to a plain address (1 or 4) loads the plane. Reads of addresses 1 to 3 return M0, and reads of addresses 4 to 6 return M1.
- R9: A read of address 0 returns pad_in_i through two flops. A level applied before clock edge k is first visible after edge k+1, in every mode.
- R10: A mode write sampled at a clock edge changes the pad outputs right after that same edge.
- R11: A write to address 7 changes neither plane, and a read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register word address |
| wdata_i | input | NUM_PINS | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | NUM_PINS | Read data (combinational from addr_i) |
| periph_out_i | input | NUM_SHARED | Peripheral output value per shared pin |
| periph_oe_i | input | NUM_SHARED | Peripheral output enable per shared pin |
| pad_out_o | output | NUM_PINS | Pad output value |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_in_i | input | NUM_PINS | Pad input level (asynchronous) |

## Verification
The assertions check the following on every cycle:
- the pad outputs for each mode code, including the rule that a dedicated pin never drives while M1 is low;
- the bit-retention effect of set and clear writes;
- the two-cycle latency of the synchronizer.

Only the bench's scenarios can show the behaviour that needs a sequence of accesses:
- the reset values;
- the readback of each address, including the aliases and the unmapped address;
- that a write to the unmapped address leaves both planes alone;
- that a pad level is still hidden after one clock edge.

// File: rtl/pin_mode_pkg.sv
package pin_mode_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_INPUT  = 2'b00,
    MODE_PERIPH = 2'b01,
    MODE_LOW    = 2'b10,
    MODE_HIGH   = 2'b11
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] ADDR_PIN    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_M0     = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_M0_SET = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_M0_CLR = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_M1     = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_M1_SET = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_M1_CLR = 3'd6;
endpackage

// File: rtl/pin_mode_plane.sv
module pin_mode_plane #(
  parameter int           W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] base, nxt;

  // clear applied last, so it wins over set on the same bit
  always_comb begin
    base = load_i ? wdata_i : q_o;
    nxt  = (base | (set_i ? wdata_i : '0)) & ~(clr_i ? wdata_i : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      q_o <= RST;
    else if (load_i || set_i || clr_i) q_o <= nxt;
  end

  assert_set_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !load_i && !clr_i) |=> (q_o == ($past(q_o) | $past(wdata_i))));

  assert_clr_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load_i && !set_i) |=> (q_o == ($past(q_o) & ~$past(wdata_i))));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

  // cycles since reset, for the latency check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_pin_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/pin_pad_ctrl.sv
module pin_pad_ctrl #(
  parameter bit SHARED = 1'b1
) (
  input  logic [1:0] mode_i,
  input  logic       periph_out_i,
  input  logic       periph_oe_i,
  output logic       pad_out_o,
  output logic       pad_oe_o
);
  import pin_mode_pkg::*;

  generate
    if (SHARED) begin : g_shared
      always_comb begin
        unique case (pin_mode_e'(mode_i))
          MODE_PERIPH: begin pad_oe_o = periph_oe_i; pad_out_o = periph_out_i; end
          MODE_LOW:    begin pad_oe_o = 1'b1;        pad_out_o = 1'b0;         end
          MODE_HIGH:   begin pad_oe_o = 1'b1;        pad_out_o = 1'b1;         end
          default:     begin pad_oe_o = 1'b0;        pad_out_o = 1'b0;         end
        endcase
      end
    end else begin : g_dedicated
      logic unused_periph;
      assign unused_periph = periph_out_i ^ periph_oe_i;
      // no peripheral mode: code 01 falls back to input
      assign pad_oe_o  = mode_i[1];
      assign pad_out_o = mode_i[1] & mode_i[0];
    end
  endgenerate
endmodule

// File: rtl/pin_mode_ctrl.sv
module pin_mode_ctrl
  import pin_mode_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_SHARED = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic                  we_i,
  output logic [NUM_PINS-1:0]   rdata_o,
  input  logic [NUM_SHARED-1:0] periph_out_i,
  input  logic [NUM_SHARED-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  input  logic [NUM_PINS-1:0]   pad_in_i
);
  function automatic logic [NUM_PINS-1:0] shared_mask();
    logic [NUM_PINS-1:0] m;
    for (int i = 0; i < NUM_PINS; i++) m[i] = (i < NUM_SHARED);
    return m;
  endfunction

  localparam logic [NUM_PINS-1:0] M0_RST = shared_mask();

  logic [NUM_PINS-1:0] m0_q, m1_q, pin_q;

  pin_mode_plane #(.W(NUM_PINS), .RST(M0_RST)) u_m0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (we_i && addr_i == ADDR_M0),
    .set_i   (we_i && addr_i == ADDR_M0_SET),
    .clr_i   (we_i && addr_i == ADDR_M0_CLR),
    .wdata_i (wdata_i),
    .q_o     (m0_q)
  );

  pin_mode_plane #(.W(NUM_PINS), .RST('0)) u_m1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (we_i && addr_i == ADDR_M1),
    .set_i   (we_i && addr_i == ADDR_M1_SET),
    .clr_i   (we_i && addr_i == ADDR_M1_CLR),
    .wdata_i (wdata_i),
    .q_o     (m1_q)
  );

  pin_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_q)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_PIN:                           rdata_o = pin_q;
      ADDR_M0, ADDR_M0_SET, ADDR_M0_CLR:  rdata_o = m0_q;
      ADDR_M1, ADDR_M1_SET, ADDR_M1_CLR:  rdata_o = m1_q;
      default:                            rdata_o = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < NUM_SHARED) begin : g_sh
      pin_pad_ctrl #(.SHARED(1'b1)) u_pad (
        .mode_i       ({m1_q[i], m0_q[i]}),
        .periph_out_i (periph_out_i[i]),
        .periph_oe_i  (periph_oe_i[i]),
        .pad_out_o    (pad_out_o[i]),
        .pad_oe_o     (pad_oe_o[i])
      );

      assert_periph_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({m1_q[i], m0_q[i]} == 2'b01) |->
          (pad_oe_o[i] == periph_oe_i[i] && pad_out_o[i] == periph_out_i[i]));
    end else begin : g_ded
      pin_pad_ctrl #(.SHARED(1'b0)) u_pad (
        .mode_i       ({m1_q[i], m0_q[i]}),
        .periph_out_i (1'b0),
        .periph_oe_i  (1'b0),
        .pad_out_o    (pad_out_o[i]),
        .pad_oe_o     (pad_oe_o[i])
      );

      assert_no_periph_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !m1_q[i] |-> (!pad_oe_o[i] && !pad_out_o[i]));
    end

    assert_input_float_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({m1_q[i], m0_q[i]} == 2'b00) |-> (!pad_oe_o[i] && !pad_out_o[i]));

    assert_drive_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m1_q[i] |-> (pad_oe_o[i] && pad_out_o[i] == m0_q[i]));
  end
endmodule

// File: tb/pin_mode_ctrl_bench.sv
module pin_mode_ctrl_bench;
  localparam int NP = 16;
  localparam int NS = 12;
  localparam logic [NP-1:0] SH = 16'h0FFF;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    addr = '0;
  logic [NP-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [NP-1:0] rdata;
  logic [NS-1:0] p_out = '0, p_oe = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NP-1:0] pad_in = '0;

  int checks = 0, errors = 0;
  logic [NP-1:0] m0, m1;

  always #4 clk = ~clk;

  pin_mode_ctrl #(.NUM_PINS(NP), .NUM_SHARED(NS)) u_pin_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .periph_out_i(p_out), .periph_oe_i(p_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_in_i(pad_in));

  task automatic check(input bit ok, input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_oe(logic [NP-1:0] a0, logic [NP-1:0] a1, logic [NS-1:0] poe);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i] = a1[i] ? 1'b1 : ((a0[i] && i < NS) ? poe[i] : 1'b0);
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_out(logic [NP-1:0] a0, logic [NP-1:0] a1, logic [NS-1:0] po);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[i] = a1[i] ? a0[i] : ((a0[i] && i < NS) ? po[i] : 1'b0);
    return r;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    case (a)
      3'd1: m0 = d;
      3'd2: m0 = m0 | d;
      3'd3: m0 = m0 & ~d;
      3'd4: m1 = d;
      3'd5: m1 = m1 | d;
      3'd6: m1 = m1 & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check_planes(input string req);
    logic [NP-1:0] v;
    rd(3'd1, v); check(v === m0, req, v, m0);
    rd(3'd4, v); check(v === m1, req, v, m1);
  endtask

  task automatic check_pads(input string req);
    logic [NP-1:0] eo, ev;
    #1;
    eo = exp_oe(m0, m1, p_oe);
    ev = exp_out(m0, m1, p_out);
    check(pad_oe === eo, req, pad_oe, eo);
    check(pad_out === ev, req, pad_out, ev);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NP-1:0] v;
    void'($urandom(32'h5eed_1234));
    m0 = SH; m1 = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_planes("R1 reset");
    p_oe = 12'hA5C; p_out = 12'h3C6;
    check_pads("R1/R3 reset pads");

    // R2/R4/R5 each mode on all pins
    wr(3'd1, '0); wr(3'd4, '0);
    check_pads("R2 input mode");
    check(pad_oe === '0, "R2 oe low", pad_oe, '0);
    wr(3'd1, '1);
    p_oe = '1; p_out = '1;
    check_pads("R3/R5 periph code");
    check(pad_oe[NP-1:NS] === '0, "R5 dedicated no periph", pad_oe, '0);
    wr(3'd4, '1);
    check_pads("R4 drive high");
    wr(3'd1, '0);
    check_pads("R4 drive low");

    // R6/R7 directed set and clear
    wr(3'd4, 16'h0000); wr(3'd1, 16'h00F0);
    wr(3'd2, 16'h0F0F); check_planes("R6 set alias");
    wr(3'd3, 16'h00FF); check_planes("R7 clear alias");
    wr(3'd5, 16'h8001); check_planes("R6 set alias m1");
    wr(3'd6, 16'h0001); check_planes("R7 clear alias m1");

    // R11 unmapped
    wr(3'd7, '1); check_planes("R11 unmapped write");
    rd(3'd7, v); check(v === '0, "R11 unmapped read", v, '0);

    // R8 alias readback
    rd(3'd2, v); check(v === m0, "R8 alias read m0", v, m0);
    rd(3'd6, v); check(v === m1, "R8 alias read m1", v, m1);

    // R9 synchronizer latency
    for (int k = 0; k < 6; k++) begin
      logic [NP-1:0] oldv, newv;
      oldv = pad_in;
      newv = (k == 0) ? 16'hFFFF : NP'($urandom);
      if (newv == oldv) newv = ~oldv;
      @(negedge clk); pad_in = newv;
      @(negedge clk); rd(3'd0, v); check(v === oldv, "R9 hidden after one edge", v, oldv);
      @(negedge clk); rd(3'd0, v); check(v === newv, "R9 visible after two edges", v, newv);
    end

    // random mix: R6 R7 R8 R10 R11
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      string req;
      a = 3'($urandom_range(1, 7));
      wr(a, NP'($urandom));
      case (a)
        3'd2, 3'd5: req = "R6 random set";
        3'd3, 3'd6: req = "R7 random clear";
        3'd7:       req = "R11 random unmapped";
        default:    req = "R8 random load";
      endcase
      check_planes(req);
      p_oe = NS'($urandom); p_out = NS'($urandom);
      check_pads("R10 random pads");
      if (n % 20 == 0) begin
        @(negedge clk); pad_in = NP'($urandom);
        repeat (2) @(negedge clk);
        rd(3'd0, v); check(v === pad_in, "R9 random pin", v, pad_in);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule